// File: doc/BRIEF.md
# Serial Trim DAC Loader

The loader sets one trim channel out of a bank of 21 to an 8-bit value. A single request names the channel and the value. The loader then sends an 11-bit word over a clock and data pair that three 8-channel trim converters share. After the word is sent, it drives an encoded 2-bit load-select field to latch the word into the right converter. The channel index picks both parts of this. Its three low bits become the converter's sub-address inside the word. Its upper bits choose which converter receives the load pulse. All three converters see every word; only the one that is strobed acts on it.

A user sets up `chan`, `value` and `phase_cycles` and pulses `start` for one cycle. The request is taken only while `busy` is low. `done` pulses when the load field returns to zero. An index outside the bank raises `err` for one cycle, and nothing is sent.

The controller is a four-state machine:
- `ST_IDLE`: all lines low.
- `ST_SETUP`: clock low, data bit presented.
- `ST_HIGH`: clock high, data bit held.
- `ST_STROBE`: load field active.

The transitions are:
- IDLE→SETUP on an accepted start.
- SETUP→HIGH at the end of a phase.
- HIGH→SETUP at the end of a phase while bits remain.
- HIGH→STROBE at the end of a phase after the last bit.
- STROBE→IDLE at the end of a phase.

Every state lasts exactly P clocks, where P is the phase length.

Top module: `trim_dac_loader`

## Requirements
- R1: After reset and whenever idle, `sclk`, `sdata`, `load_sel`, `busy`, `done` and `err` are all 0.
- R2: The transmitted word is 11 bits wide. Bits 10:8 carry `chan[2:0]` and bits 7:0 carry `value`. The word is sent most significant bit first.
- R3: Each bit first appears on `sdata` with `sclk` low for P cycles. Then `sclk` is high for P cycles while `sdata` holds the same bit.
- R4: P equals `phase_cycles`, or 1 when `phase_cycles` is 0. P is captured at the accepted start, and later changes to `phase_cycles` have no effect on a transfer in progress.
- R5: After the last bit, `load_sel` equals `chan/8 + 1` (1, 2 or 3) for P cycles and then returns to 0. `load_sel` never takes the value 3 for channels 0..15 and is never active outside this window.
- R6: A start with `chan` greater than 20 is rejected. `err` is 1 for exactly the next cycle, and `busy`, `sclk`, `sdata` and `load_sel` stay 0.
- R7: `busy` rises the cycle after an accepted start and stays high for exactly 23·P cycles. A start seen while `busy` is high is ignored.
- R8: `done` is a single-cycle pulse in the cycle `busy` falls after a transfer.
- R9: `sclk` and `sdata` are both 0 while `load_sel` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse |
| chan | input | 5 | Trim channel index, 0..20 valid |
| value | input | 8 | Trim value |
| phase_cycles | input | 8 | Clocks per serial phase (0 treated as 1) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Rejected request pulse |
| sclk | output | 1 | Serial clock to the trim converters |
| sdata | output | 1 | Serial data to the trim converters |
| load_sel | output | 2 | Encoded load strobe, 0 = none, 1..3 = converter |

## Verification
The assertions assume `start` is a synchronous input that is sampled only on rising clock edges. They also assume that `chan`, `value` and `phase_cycles` are valid whenever `start` is high. The stimulus keeps within this by driving every input on the falling edge and holding `start` for exactly one cycle.

The stimulus covers:
- Valid and out-of-range channels.
- Every converter.
- A zero phase length.
- A change to `phase_cycles` during a transfer.
- A request issued while busy.
- A request issued in the same cycle as `done`.

The reference model predicts every output on every cycle from the accepted request alone.

// File: rtl/trim_pkg.sv
package trim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_HIGH   = 2'd2,
        ST_STROBE = 2'd3
    } ld_state_t;
endpackage

// File: rtl/trim_frame_build.sv
module trim_frame_build #(
    parameter int CH_COUNT = 21,
    parameter int CH_W     = 5,
    parameter int SUB_W    = 3,
    parameter int VAL_W    = 8,
    parameter int SEL_W    = 2,
    localparam int FRAME_W = SUB_W + VAL_W
) (
    input  logic [CH_W-1:0]    chan,
    input  logic [VAL_W-1:0]   value,
    output logic [FRAME_W-1:0] frame,
    output logic [SEL_W-1:0]   sel_code,
    output logic               chan_ok
);
    always_comb begin
        frame    = {chan[SUB_W-1:0], value};
        sel_code = SEL_W'(chan >> SUB_W) + SEL_W'(1);
        chan_ok  = (chan < CH_W'(CH_COUNT));
    end
endmodule

// File: rtl/trim_phase_timer.sv
module trim_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] len,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = run && (cnt == len - W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/trim_shift_reg.sv
module trim_shift_reg #(
    parameter int W = 11,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] frame,
    input  logic         shift,
    output logic         msb,
    output logic         last_bit
);
    logic [W-1:0]  sr;
    logic [CW-1:0] rem;

    assign msb      = sr[W-1];
    assign last_bit = (rem == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            rem <= '0;
        end else if (load) begin
            sr  <= frame;
            rem <= CW'(W - 1);
        end else if (shift) begin
            sr  <= {sr[W-2:0], 1'b0};
            rem <= rem - CW'(1);
        end
    end
endmodule

// File: rtl/trim_dac_loader.sv
module trim_dac_loader
    import trim_pkg::*;
#(
    parameter int CH_COUNT = 21,
    parameter int SUB_W    = 3,
    parameter int VAL_W    = 8,
    parameter int SEL_W    = 2,
    parameter int PH_W     = 8,
    localparam int CH_W    = $clog2(CH_COUNT),
    localparam int FRAME_W = SUB_W + VAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CH_W-1:0]  chan,
    input  logic [VAL_W-1:0] value,
    input  logic [PH_W-1:0]  phase_cycles,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             sclk,
    output logic             sdata,
    output logic [SEL_W-1:0] load_sel
);
    ld_state_t            state, state_nx;
    logic [FRAME_W-1:0]   frame;
    logic [SEL_W-1:0]     sel_code, sel_q;
    logic                 chan_ok;
    logic [PH_W-1:0]      phase_q;
    logic                 accept, reject, tick, msb, last_bit, shift;
    logic                 done_q, err_q;

    trim_frame_build #(
        .CH_COUNT(CH_COUNT), .CH_W(CH_W), .SUB_W(SUB_W),
        .VAL_W(VAL_W), .SEL_W(SEL_W)
    ) u_frame (
        .chan(chan), .value(value), .frame(frame),
        .sel_code(sel_code), .chan_ok(chan_ok)
    );

    trim_phase_timer #(.W(PH_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE),
        .len(phase_q), .tick(tick)
    );

    trim_shift_reg #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept), .frame(frame),
        .shift(shift), .msb(msb), .last_bit(last_bit)
    );

    assign accept = (state == ST_IDLE) && start && chan_ok;
    assign reject = (state == ST_IDLE) && start && !chan_ok;
    assign shift  = (state == ST_HIGH) && tick && !last_bit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase_q <= PH_W'(1);
            sel_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= (state == ST_STROBE) && tick;
            err_q  <= reject;
            if (accept) begin
                phase_q <= (phase_cycles == '0) ? PH_W'(1) : phase_cycles;
                sel_q   <= sel_code;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_SETUP;
            ST_SETUP:  if (tick)   state_nx = ST_HIGH;
            ST_HIGH:   if (tick)   state_nx = last_bit ? ST_STROBE : ST_SETUP;
            ST_STROBE: if (tick)   state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        sclk     = 1'b0;
        sdata    = 1'b0;
        load_sel = '0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_SETUP:  sdata = msb;
            ST_HIGH: begin
                sclk  = 1'b1;
                sdata = msb;
            end
            ST_STROBE: load_sel = sel_q;
            default:   busy = 1'b0;
        endcase
        done = done_q;
        err  = err_q;
    end
endmodule

// File: rtl/trim_dac_loader_chk.sv
module trim_dac_loader_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             sclk,
    input logic             sdata,
    input logic [SEL_W-1:0] load_sel
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdata && load_sel == '0)); // R1
    AST_DATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdata)); // R3
    AST_DATA_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata)); // R3
    AST_LOAD_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (load_sel != '0) |-> (!sclk && !sdata)); // R9
    AST_LOAD_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_sel) != '0 && load_sel == '0) |-> done); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy); // R6
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R6
endmodule

bind trim_dac_loader trim_dac_loader_chk #(.SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .sclk(sclk), .sdata(sdata), .load_sel(load_sel)
);

// File: tb/tb_trim_dac_loader.sv
module tb_trim_dac_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] chan = '0;
    logic [7:0] value = '0;
    logic [7:0] phase_cycles = 8'd1;
    logic       busy, done, err, sclk, sdata;
    logic [1:0] load_sel;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    trim_dac_loader dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .value(value),
        .phase_cycles(phase_cycles), .busy(busy), .done(done), .err(err),
        .sclk(sclk), .sdata(sdata), .load_sel(load_sel)
    );

    // behavioural reference model
    bit         m_active, m_done, m_err;
    int         t, p;
    bit [10:0]  m_frame;
    int         m_sel;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_done = 0; m_err = 0; t = 0; p = 1;
        end else begin
            m_done = 0;
            m_err  = 0;
            if (m_active) begin
                t++;
                if (t == 23 * p) begin
                    m_active = 0;
                    m_done   = 1;
                end
            end else if (start) begin
                if (chan > 20) m_err = 1;
                else begin
                    m_active = 1;
                    t        = 0;
                    p        = (phase_cycles == 0) ? 1 : int'(phase_cycles);
                    m_frame  = {chan[2:0], value};
                    m_sel    = int'(chan) / 8 + 1;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    bit compare_on = 0;
    always @(negedge clk) begin
        if (rst_n && compare_on) begin
            int ph, e_sclk, e_sdata, e_load;
            ph = m_active ? t / p : 0;
            e_sclk = 0; e_sdata = 0; e_load = 0;
            if (m_active) begin
                if (ph < 22) begin
                    e_sclk  = ph % 2;
                    e_sdata = int'(m_frame[10 - ph / 2]);
                end else e_load = m_sel;
            end
            chk("R3 sclk", int'(sclk), e_sclk);
            chk("R2 sdata", int'(sdata), e_sdata);
            chk("R5 load_sel", int'(load_sel), e_load);
            chk("R7 busy", int'(busy), int'(m_active));
            chk("R8 done", int'(done), int'(m_done));
            chk("R6 err", int'(err), int'(m_err));
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic request(int ch, int val, int ph);
        @(negedge clk);
        start = 1'b1; chan = 5'(ch); value = 8'(val); phase_cycles = 8'(ph);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset lines", int'({sclk, sdata, load_sel}), 0);
        chk("R1 reset flags", int'({done, err}), 0);
        compare_on = 1;

        request(0, 8'hA5, 1);  wait_idle();            // R2 chip 1
        request(20, 8'h3C, 3); wait_idle();            // R5 chip 3, sub 4
        request(13, 8'hFF, 0); wait_idle();            // R4 zero phase
        request(21, 8'h55, 2); repeat (4) @(negedge clk); // R6
        chk("R6 no transfer", int'(busy), 0);
        request(31, 8'h01, 1); repeat (4) @(negedge clk); // R6

        // R4 phase change mid-transfer, R7 start while busy ignored
        request(7, 8'h81, 2);
        repeat (5) @(negedge clk);
        phase_cycles = 8'd5;
        request(9, 8'h0F, 1);
        wait_idle();

        // R8 back-to-back: new request in the done cycle
        request(8, 8'h00, 1);
        while (!done) @(negedge clk);
        start = 1'b1; chan = 5'd16; value = 8'hC3; phase_cycles = 8'd2;
        @(negedge clk);
        start = 1'b0;
        chk("R7 accepted after done", int'(busy), 1);
        wait_idle();

        request(15, 8'h5A, 4); wait_idle();            // R9 chip 2
        summary();
    end
endmodule